// File: doc/BRIEF.md
# Multi-Wide Register Rename Unit

This block maps a group of up to `W` decoded instructions per cycle from architectural register names to physical register names. It keeps a speculative map table, one physical tag per architectural register, and a bitvector of free physical registers. For every slot it returns the physical tags of both sources, a freshly allocated destination tag, and the physical tag the destination held before. A later stage carries that previous tag with the instruction. When the instruction retires, it hands the tag back through the retire pins, and the register rejoins the free pool.

Within one group, a source that names an architectural register written by an earlier slot takes that slot's new tag. When several slots write the same register, the map keeps the last slot's tag, and each writer's previous tag is the one given by the nearest earlier writer. Architectural register 0 is a constant zero. It is never renamed and always reads physical register 0.

The group arrives on a valid/ready stream. `in_ready` is a combinational function of the current group and the free pool, so it may depend on `in_valid` and the slot fields. A group is taken in the cycle where both `in_valid` and `in_ready` are high. The results are combinational in that same cycle, flagged by `out_valid`, and the state updates at the following clock edge. A group that is not taken must be held by the sender, and it leaves the map and the free pool untouched. The retire pins are plain control inputs with no handshake.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers NARCH to NPHYS-1 are free and registers 0 to NARCH-1 are not.
- R2: A source whose register is not written by an earlier slot of the same group reads the current map table entry.
- R3: Each slot that needs a destination receives the lowest-numbered free physical register left after the earlier slots have taken theirs. The tags within a group are distinct and never 0. A slot with no destination outputs destination tag 0.
- R4: After a group is taken, the map entry of each written architectural register holds the newly allocated tag, and later groups read that tag.
- R5: Each slot that needs a destination outputs, as its previous tag, the mapping its destination register had before this slot was renamed. A slot with no destination outputs 0.
- R6: A source that names the destination of an earlier slot in the same group reads the tag allocated to the nearest such slot.
- R7: When several slots in a group write the same register, the map keeps the last slot's tag. Each writer's previous tag is the tag of the nearest earlier writer.
- R8: Architectural register 0 as a source always reads physical 0. As a destination it allocates nothing and changes no state.
- R9: If the free pool holds fewer registers than the group needs, `in_ready` is low and the map and the free pool are unchanged. A group that needs no register is always accepted.
- R10: A retired previous tag becomes free at the next clock edge. It can be allocated no earlier than the following cycle, and retiring tag 0 has no effect.
- R11: With `in_valid` low, or with a slot's `slot_valid` bit low, that slot allocates nothing and changes no state. `out_valid` equals `in_valid && in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Group present |
| in_ready | output | 1 | Group can be taken this cycle |
| slot_valid | input | W | Per-slot instruction present |
| slot_has_dst | input | W | Per-slot instruction writes a register |
| slot_dst_arch | input | W*5 | Per-slot architectural destination, slot i at bits [i*5 +: 5] |
| slot_src1_arch | input | W*5 | Per-slot first architectural source |
| slot_src2_arch | input | W*5 | Per-slot second architectural source |
| ret_valid | input | W | Per-lane retire strobe |
| ret_tag | input | W*6 | Per-lane previous tag to free, lane k at bits [k*6 +: 6] |
| out_valid | output | 1 | Group taken this cycle |
| out_src1_tag | output | W*6 | Physical tag of each slot's first source |
| out_src2_tag | output | W*6 | Physical tag of each slot's second source |
| out_dst_tag | output | W*6 | Newly allocated destination tag, 0 when none |
| out_old_tag | output | W*6 | Previous mapping of the destination, 0 when none |

## Verification
On every cycle, the assertions check the following. Register 0 reads physical 0. A taken group's new tags are distinct, nonzero, and never equal to a tag being retired in the same cycle. A group needing no registers is never stalled. A source naming the preceding slot's destination picks up that slot's tag. The bench's directed scenarios are the only place the time-dependent behaviour is shown: the lowest-first allocation order, the map updates seen by later groups, previous-tag chaining across several writers, stalls that leave no trace, and the one-cycle delay before a retired register can be reused.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_WIDTH_DEF = 4;
  localparam int RN_ARCH_DEF  = 32;
  localparam int RN_PHYS_DEF  = 64;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int W     = rn_pkg::RN_WIDTH_DEF,
  parameter int NARCH = rn_pkg::RN_ARCH_DEF,
  parameter int NPHYS = rn_pkg::RN_PHYS_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W-1:0]              need,
  input  logic                      commit,
  input  logic [W-1:0]              rel_valid,
  input  logic [W*$clog2(NPHYS)-1:0] rel_tag,
  output logic [W*$clog2(NPHYS)-1:0] alloc_tag,
  output logic [$clog2(NPHYS+1)-1:0] free_cnt
);
  localparam int PW = $clog2(NPHYS);
  localparam int CW = $clog2(NPHYS + 1);

  logic [NPHYS-1:0] free_q;
  logic [NPHYS-1:0] avail [W+1];
  logic [NPHYS-1:0] rel_mask;

  assign avail[0] = free_q;

  for (genvar i = 0; i < W; i++) begin : g_pick
    logic [PW-1:0] pick;
    logic          hit;
    always_comb begin
      pick = '0;
      hit  = 1'b0;
      for (int p = NPHYS - 1; p >= 0; p--) begin
        if (avail[i][p]) begin
          pick = PW'(p);
          hit  = 1'b1;
        end
      end
    end
    assign avail[i+1] = (need[i] && hit) ? (avail[i] & ~(NPHYS'(1) << pick)) : avail[i];
    assign alloc_tag[i*PW +: PW] = (need[i] && hit) ? pick : '0;
  end

  always_comb begin
    rel_mask = '0;
    for (int k = 0; k < W; k++) begin
      if (rel_valid[k] && (rel_tag[k*PW +: PW] != '0)) begin
        rel_mask = rel_mask | (NPHYS'(1) << rel_tag[k*PW +: PW]);
      end
    end
  end

  assign free_cnt = CW'($countones(free_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q <= {{(NPHYS-NARCH){1'b1}}, {NARCH{1'b0}}};
    end else if (commit) begin
      free_q <= avail[W] | rel_mask;
    end else begin
      free_q <= free_q | rel_mask;
    end
  end
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
  parameter int W     = rn_pkg::RN_WIDTH_DEF,
  parameter int NARCH = rn_pkg::RN_ARCH_DEF,
  parameter int NPHYS = rn_pkg::RN_PHYS_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [W-1:0]                  wr_en,
  input  logic [W*$clog2(NARCH)-1:0]    wr_arch,
  input  logic [W*$clog2(NPHYS)-1:0]    wr_tag,
  output logic [NARCH*$clog2(NPHYS)-1:0] map_flat
);
  localparam int AW = $clog2(NARCH);
  localparam int PW = $clog2(NPHYS);

  logic [PW-1:0] map_q [NARCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NARCH; a++) map_q[a] <= PW'(a);
    end else begin
      for (int i = 0; i < W; i++) begin
        if (wr_en[i] && (wr_arch[i*AW +: AW] != '0)) begin
          map_q[wr_arch[i*AW +: AW]] <= wr_tag[i*PW +: PW];
        end
      end
    end
  end

  assign map_flat[PW-1:0] = '0;
  for (genvar a = 1; a < NARCH; a++) begin : g_flat
    assign map_flat[a*PW +: PW] = map_q[a];
  end
endmodule

// File: rtl/rn_bypass.sv
module rn_bypass #(
  parameter int W     = rn_pkg::RN_WIDTH_DEF,
  parameter int NARCH = rn_pkg::RN_ARCH_DEF,
  parameter int NPHYS = rn_pkg::RN_PHYS_DEF
) (
  input  logic [NARCH*$clog2(NPHYS)-1:0] map_flat,
  input  logic [W-1:0]                   need,
  input  logic [W*$clog2(NARCH)-1:0]     dst_arch,
  input  logic [W*$clog2(NARCH)-1:0]     src1_arch,
  input  logic [W*$clog2(NARCH)-1:0]     src2_arch,
  input  logic [W*$clog2(NPHYS)-1:0]     alloc_tag,
  output logic [W*$clog2(NPHYS)-1:0]     src1_tag,
  output logic [W*$clog2(NPHYS)-1:0]     src2_tag,
  output logic [W*$clog2(NPHYS)-1:0]     old_tag
);
  localparam int AW = $clog2(NARCH);
  localparam int PW = $clog2(NPHYS);

  for (genvar i = 0; i < W; i++) begin : g_slot
    logic [AW-1:0] s1, s2, d;
    logic [PW-1:0] t1, t2, to;
    assign s1 = src1_arch[i*AW +: AW];
    assign s2 = src2_arch[i*AW +: AW];
    assign d  = dst_arch[i*AW +: AW];
    always_comb begin
      t1 = map_flat[s1*PW +: PW];
      t2 = map_flat[s2*PW +: PW];
      to = map_flat[d*PW +: PW];
      for (int j = 0; j < i; j++) begin
        if (need[j] && (dst_arch[j*AW +: AW] == s1)) t1 = alloc_tag[j*PW +: PW];
        if (need[j] && (dst_arch[j*AW +: AW] == s2)) t2 = alloc_tag[j*PW +: PW];
        if (need[j] && (dst_arch[j*AW +: AW] == d))  to = alloc_tag[j*PW +: PW];
      end
      if (s1 == '0) t1 = '0;
      if (s2 == '0) t2 = '0;
      if (!need[i]) to = '0;
    end
    assign src1_tag[i*PW +: PW] = t1;
    assign src2_tag[i*PW +: PW] = t2;
    assign old_tag[i*PW +: PW]  = to;
  end
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int W     = rn_pkg::RN_WIDTH_DEF,
  parameter int NARCH = rn_pkg::RN_ARCH_DEF,
  parameter int NPHYS = rn_pkg::RN_PHYS_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [W-1:0]               slot_valid,
  input  logic [W-1:0]               slot_has_dst,
  input  logic [W*$clog2(NARCH)-1:0] slot_dst_arch,
  input  logic [W*$clog2(NARCH)-1:0] slot_src1_arch,
  input  logic [W*$clog2(NARCH)-1:0] slot_src2_arch,
  input  logic [W-1:0]               ret_valid,
  input  logic [W*$clog2(NPHYS)-1:0] ret_tag,
  output logic                       out_valid,
  output logic [W*$clog2(NPHYS)-1:0] out_src1_tag,
  output logic [W*$clog2(NPHYS)-1:0] out_src2_tag,
  output logic [W*$clog2(NPHYS)-1:0] out_dst_tag,
  output logic [W*$clog2(NPHYS)-1:0] out_old_tag
);
  localparam int AW = $clog2(NARCH);
  localparam int PW = $clog2(NPHYS);
  localparam int CW = $clog2(NPHYS + 1);

  logic [W-1:0]           need;
  logic [CW-1:0]          free_cnt;
  logic [CW-1:0]          need_cnt;
  logic                   fire;
  logic [W*PW-1:0]        alloc_tag;
  logic [NARCH*PW-1:0]    map_flat;

  for (genvar i = 0; i < W; i++) begin : g_need
    assign need[i] = in_valid && slot_valid[i] && slot_has_dst[i] &&
                     (slot_dst_arch[i*AW +: AW] != '0);
  end

  assign need_cnt  = CW'($countones(need));
  assign in_ready  = (free_cnt >= need_cnt);
  assign fire      = in_valid && in_ready;
  assign out_valid = fire;

  rn_freelist #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .need      (need),
    .commit    (fire),
    .rel_valid (ret_valid),
    .rel_tag   (ret_tag),
    .alloc_tag (alloc_tag),
    .free_cnt  (free_cnt)
  );

  rn_maptable #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (need & {W{fire}}),
    .wr_arch  (slot_dst_arch),
    .wr_tag   (alloc_tag),
    .map_flat (map_flat)
  );

  rn_bypass #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS)) u_byp (
    .map_flat  (map_flat),
    .need      (need),
    .dst_arch  (slot_dst_arch),
    .src1_arch (slot_src1_arch),
    .src2_arch (slot_src2_arch),
    .alloc_tag (alloc_tag),
    .src1_tag  (out_src1_tag),
    .src2_tag  (out_src2_tag),
    .old_tag   (out_old_tag)
  );

  assign out_dst_tag = alloc_tag;
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int W     = rn_pkg::RN_WIDTH_DEF,
  parameter int NARCH = rn_pkg::RN_ARCH_DEF,
  parameter int NPHYS = rn_pkg::RN_PHYS_DEF
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [W-1:0]               slot_valid,
  input logic [W-1:0]               slot_has_dst,
  input logic [W*$clog2(NARCH)-1:0] slot_dst_arch,
  input logic [W*$clog2(NARCH)-1:0] slot_src1_arch,
  input logic [W*$clog2(NARCH)-1:0] slot_src2_arch,
  input logic [W-1:0]               ret_valid,
  input logic [W*$clog2(NPHYS)-1:0] ret_tag,
  input logic                       out_valid,
  input logic [W*$clog2(NPHYS)-1:0] out_src1_tag,
  input logic [W*$clog2(NPHYS)-1:0] out_src2_tag,
  input logic [W*$clog2(NPHYS)-1:0] out_dst_tag,
  input logic [W*$clog2(NPHYS)-1:0] out_old_tag
);
  localparam int AW = $clog2(NARCH);
  localparam int PW = $clog2(NPHYS);

  logic [W-1:0] wants;
  logic         dup;

  for (genvar i = 0; i < W; i++) begin : g_w
    assign wants[i] = slot_valid[i] && slot_has_dst[i] && (slot_dst_arch[i*AW +: AW] != '0);
  end

  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < W; a++) begin
      for (int b = a + 1; b < W; b++) begin
        if (wants[a] && wants[b] && (out_dst_tag[a*PW +: PW] == out_dst_tag[b*PW +: PW])) dup = 1'b1;
      end
    end
  end

  // R3
  distinct_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !dup);

  // R9
  no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (wants == '0)) |-> in_ready);

  for (genvar i = 0; i < W; i++) begin : g_slot
    // R8
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && slot_valid[i] && (slot_src1_arch[i*AW +: AW] == '0)) |->
      (out_src1_tag[i*PW +: PW] == '0));

    // R3
    nonzero_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wants[i]) |-> (out_dst_tag[i*PW +: PW] != '0));

    for (genvar k = 0; k < W; k++) begin : g_ret
      // R10
      fresh_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wants[i] && ret_valid[k]) |->
        (out_dst_tag[i*PW +: PW] != ret_tag[k*PW +: PW]));
    end

    if (i > 0) begin : g_fwd
      // R6
      fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wants[i-1] && slot_valid[i] &&
         (slot_src1_arch[i*AW +: AW] == slot_dst_arch[(i-1)*AW +: AW])) |->
        (out_src1_tag[i*PW +: PW] == out_dst_tag[(i-1)*PW +: PW]));
    end
  end
endmodule

bind rn_rename_unit rn_rename_chk #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS)) u_chk (.*);

// File: tb/rn_rename_unit_bench.sv
`timescale 1ns/1ps
module rn_rename_unit_bench;
  localparam int W = 4, NARCH = 32, NPHYS = 64;
  localparam int AW = 5, PW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, out_valid;
  logic [W-1:0] slot_valid = '0, slot_has_dst = '0, ret_valid = '0;
  logic [W*AW-1:0] slot_dst_arch = '0, slot_src1_arch = '0, slot_src2_arch = '0;
  logic [W*PW-1:0] ret_tag = '0;
  logic [W*PW-1:0] out_src1_tag, out_src2_tag, out_dst_tag, out_old_tag;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rn_rename_unit #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS)) u_rn_rename_unit (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; slot_valid = '0; slot_has_dst = '0; ret_valid = '0;
    slot_dst_arch = '0; slot_src1_arch = '0; slot_src2_arch = '0; ret_tag = '0;
  endtask

  task automatic put(input int i, input bit hd, input int d, input int s1, input int s2);
    slot_valid[i] = 1'b1;
    slot_has_dst[i] = hd;
    slot_dst_arch[i*AW +: AW] = AW'(d);
    slot_src1_arch[i*AW +: AW] = AW'(s1);
    slot_src2_arch[i*AW +: AW] = AW'(s2);
  endtask

  task automatic retire(input int k, input int t);
    ret_valid[k] = 1'b1;
    ret_tag[k*PW +: PW] = PW'(t);
  endtask

  function automatic int s1t(input int i); return int'(out_src1_tag[i*PW +: PW]); endfunction
  function automatic int s2t(input int i); return int'(out_src2_tag[i*PW +: PW]); endfunction
  function automatic int dt(input int i);  return int'(out_dst_tag[i*PW +: PW]);  endfunction
  function automatic int ot(input int i);  return int'(out_old_tag[i*PW +: PW]);  endfunction

  task automatic begin_step();
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic t_reset();
    begin_step();
    in_valid = 1'b1;
    put(0, 1'b0, 0, 5, 0);
    settle();
    chk("R1 ready after reset", in_ready, 1);
    chk("R11 out_valid on take", out_valid, 1);
    chk("R1 identity map src", s1t(0), 5);
    chk("R8 zero source", s2t(0), 0);
    chk("R3 no dst tag", dt(0), 0);
    chk("R5 no dst old", ot(0), 0);
  endtask

  task automatic t_group();
    begin_step();
    in_valid = 1'b1;
    put(0, 1'b1, 1, 2, 3);
    put(1, 1'b1, 4, 1, 5);
    put(2, 1'b1, 1, 1, 4);
    put(3, 1'b1, 0, 0, 1);
    settle();
    chk("R2 map source", s2t(0), 3);
    chk("R1 first free lowest", dt(0), 32);
    chk("R5 old slot0", ot(0), 1);
    chk("R6 forward slot1", s1t(1), 32);
    chk("R3 second alloc", dt(1), 33);
    chk("R5 old slot1", ot(1), 4);
    chk("R6 forward slot2 src2", s2t(2), 33);
    chk("R3 third alloc", dt(2), 34);
    chk("R7 old chain", ot(2), 32);
    chk("R8 zero src slot3", s1t(3), 0);
    chk("R8 zero dst no alloc", dt(3), 0);
    chk("R7 latest forward", s2t(3), 34);
  endtask

  task automatic t_update_ignore();
    begin_step();
    put(0, 1'b1, 7, 1, 0);
    settle();
    chk("R11 no take when invalid", out_valid, 0);
    begin_step();
    in_valid = 1'b1;
    put(0, 1'b0, 0, 1, 4);
    put(1, 1'b1, 7, 7, 0);
    put(2, 1'b1, 9, 0, 0);
    slot_valid[2] = 1'b0;
    settle();
    chk("R7 map takes last writer", s1t(0), 34);
    chk("R4 map updated", s2t(0), 33);
    chk("R11 ignored group no map write", s1t(1), 7);
    chk("R11 ignored group no alloc", dt(1), 35);
    chk("R5 old of r7", ot(1), 7);
  endtask

  task automatic t_retire();
    begin_step();
    in_valid = 1'b1;
    retire(0, 1);
    retire(1, 4);
    put(0, 1'b1, 8, 0, 0);
    settle();
    chk("R10 freed not same cycle", dt(0), 36);
    begin_step();
    in_valid = 1'b1;
    put(0, 1'b1, 9, 0, 0);
    settle();
    chk("R10 freed reused next cycle", dt(0), 1);
    chk("R5 old r9", ot(0), 9);
    begin_step();
    in_valid = 1'b1;
    put(0, 1'b1, 10, 0, 0);
    put(1, 1'b1, 11, 0, 0);
    settle();
    chk("R10 second freed", dt(0), 4);
    chk("R3 lowest after freed", dt(1), 37);
  endtask

  task automatic t_stall();
    for (int g = 0; g < 6; g++) begin
      begin_step();
      in_valid = 1'b1;
      for (int i = 0; i < W; i++) put(i, 1'b1, 12, 0, 0);
      settle();
      chk("R3 fill slot3", dt(3), 38 + 4*g + 3);
      chk("R7 chained old", ot(3), 38 + 4*g + 2);
    end
    begin_step();
    in_valid = 1'b1;
    put(0, 1'b1, 20, 0, 0);
    put(1, 1'b1, 21, 0, 0);
    put(2, 1'b1, 22, 0, 0);
    settle();
    chk("R9 stall short pool", in_ready, 0);
    chk("R11 no take on stall", out_valid, 0);
    begin_step();
    in_valid = 1'b1;
    put(0, 1'b0, 0, 20, 0);
    put(1, 1'b1, 23, 0, 0);
    put(2, 1'b1, 24, 0, 0);
    settle();
    chk("R9 stalled group left map", s1t(0), 20);
    chk("R9 ready exact fit", in_ready, 1);
    chk("R9 stalled group left pool a", dt(1), 62);
    chk("R9 stalled group left pool b", dt(2), 63);
    begin_step();
    in_valid = 1'b1;
    retire(0, 5);
    put(0, 1'b1, 25, 0, 0);
    settle();
    chk("R10 empty pool stall despite retire", in_ready, 0);
    begin_step();
    in_valid = 1'b1;
    retire(0, 0);
    put(0, 1'b1, 0, 12, 0);
    settle();
    chk("R9 no-need group accepted", in_ready, 1);
    chk("R4 last r12 writer", s1t(0), 61);
    chk("R8 r0 dst no tag", dt(0), 0);
    begin_step();
    in_valid = 1'b1;
    put(0, 1'b1, 25, 0, 0);
    settle();
    chk("R10 retired tag usable", in_ready, 1);
    chk("R10 retired tag allocated", dt(0), 5);
    begin_step();
    in_valid = 1'b1;
    put(0, 1'b1, 26, 0, 0);
    settle();
    chk("R10 retire of tag 0 frees nothing", in_ready, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_group();
    t_update_ignore();
    t_retire();
    t_stall();
    begin_step();
    @(negedge clk);
    summary();
  end
endmodule